// File: doc/BRIEF.md
# Iterative Feistel Block Cipher Core (128-bit block, 128-bit key)

This block encrypts or decrypts one 128-bit block at a time with an 18-round Feistel cipher. The rounds use a byte-substitution F function, two keyed mixing layers (a forward mix on one half and its inverse on the other), and whitening with separate 128-bit words before and after the rounds. A single round unit is shared across all steps. A 128-bit state register is fed through a three-way selector that picks one of three sources: the whitened input, the output of one F round, or the output of the mixing layer. After one loading edge the block takes twenty clock steps: six rounds, a mixing layer, six rounds, a second mixing layer and six final rounds. Every round swaps the halves except the last one.

Key expansion is done in a separate block. This core publishes a round-key index and a mixing-layer selector on its outputs. The key-schedule block answers on the key inputs within the same cycle. Decryption uses the same datapath. The control walks the round keys in reverse, takes the two mixing-layer key words in exchanged roles, and exchanges the pre- and post-whitening words. Each S-box value is computed from a field inversion wrapped in two linear bit maps and two constants. Four related boxes are built from it by rotating the input or the output, and the eight F-function lanes use the boxes in the order 1,2,3,4,2,3,4,1.

Top module: `camFeistelCore`

## Requirements
- R1: An asynchronous active-low reset clears `done` and `dataOut` to zero and abandons any operation in progress.
- R2: Counting the rising edge that accepts `start` as edge 0, `done` is high after edge 20 and low before it. The 128-bit result is on `dataOut` while `done` is high.
- R3: `done` is high for exactly one clock cycle per completed operation.
- R4: A `start` raised while an operation is running is ignored. The running result is unchanged, and no extra completion follows.
- R5: In encrypt mode (`decrypt` = 0) the input block is XORed with `wKeyIn` before the first round. Bits 127:64 of `wKeyIn` act on the left half.
- R6: In encrypt mode the output of the last round is XORed with `wKeyOut` to form `dataOut`.
- R7: Decrypting the ciphertext with the same key inputs returns the original plaintext. For random keys the ciphertext differs from the plaintext.
- R8: The twenty steps (0..19) run rounds at steps 0-5, 7-12 and 14-19 and mixing layers at steps 6 and 13. In encrypt mode `rndKeyIdx` shows 0..17 in ascending order on the round steps, and `flSel` is 0 at step 6 and 1 at step 13. In decrypt mode `rndKeyIdx` shows 17..0 and `flSel` is 1 then 0. In encrypt mode the forward mix on the left half is keyed by `flKeyA` and the inverse mix on the right half by `flKeyB`; decrypt mode exchanges the two.
- R9: In decrypt mode `wKeyOut` whitens the input and `wKeyIn` whitens the output.
- R10: `dataOut` holds its value between completions, whatever the data and key inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accepts `dataIn` and `decrypt` when the core is idle |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt, sampled with `start` |
| dataIn | input | 128 | Plaintext or ciphertext block |
| wKeyIn | input | 128 | Whitening word applied at the input when encrypting |
| wKeyOut | input | 128 | Whitening word applied at the output when encrypting |
| rndKeyIdx | output | 5 | Index of the round key needed this cycle |
| rndKey | input | 64 | Round key for `rndKeyIdx`, returned in the same cycle |
| flSel | output | 1 | Selects which mixing-layer key pair is needed |
| flKeyA | input | 64 | First key word of the selected mixing pair |
| flKeyB | input | 64 | Second key word of the selected mixing pair |
| done | output | 1 | One-cycle completion pulse |
| dataOut | output | 128 | Result block, held until the next completion |

## Verification
The bench uses the package defaults: six rounds per group and three groups. That gives the full twenty-step schedule with both mixing layers, so every key-index and layer-select transition is reached in both directions. Round-trip decryption checks the F rounds and the mixing layers without needing a reference S-box. Shifting one whitening word by a known pattern, with or without the matching data shift, pins down which word each mode applies at each end.

// File: rtl/camFeistelPkg.sv
package camFeistelPkg;
  localparam int BLOCK_W          = 128;
  localparam int HALF_W           = BLOCK_W / 2;
  localparam int ROUNDS_PER_GROUP = 6;
  localparam int GROUP_COUNT      = 3;
  localparam int ROUND_COUNT      = ROUNDS_PER_GROUP * GROUP_COUNT;
  localparam int STEP_COUNT       = ROUND_COUNT + GROUP_COUNT - 1;
  localparam int STEP_W           = $clog2(STEP_COUNT);
  localparam int IDX_W            = $clog2(ROUND_COUNT);
  localparam int FL_W             = (GROUP_COUNT > 2) ? $clog2(GROUP_COUNT - 1) : 1;
  localparam int LANES            = HALF_W / 8;

  localparam logic [7:0] FIELD_LO = 8'h69;
  localparam logic [7:0] IN_CONST = 8'hc5;
  localparam logic [7:0] OUT_CONST = 8'h6e;

  typedef struct packed {
    logic load;
    logic rnd;
    logic fl;
    logic last;
    logic dec;
  } stepStb_t;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? FIELD_LO : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] r, base;
    r    = 8'h01;
    base = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gfMul(r, base);
      base = gfMul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] mapIn(input logic [7:0] x);
    return {x[2]^x[6], x[1]^x[7], x[0]^x[3]^x[5], x[0]^x[5],
            x[1]^x[4], x[3]^x[6], x[0]^x[7], x[2]^x[4]};
  endfunction

  function automatic logic [7:0] mapOut(input logic [7:0] x);
    return {x[3]^x[2]^x[6], x[2]^x[6], x[1]^x[4], x[0]^x[6],
            x[1]^x[5], x[0]^x[7], x[3]^x[7], x[2]^x[5]};
  endfunction

  function automatic logic [7:0] boxBase(input logic [7:0] x);
    return mapOut(gfInv(mapIn(x ^ IN_CONST))) ^ OUT_CONST;
  endfunction

  function automatic logic [7:0] boxSel(input int id, input logic [7:0] x);
    logic [7:0] b;
    case (id)
      1: begin b = boxBase(x); return {b[6:0], b[7]}; end
      2: begin b = boxBase(x); return {b[0], b[7:1]}; end
      3: return boxBase({x[6:0], x[7]});
      default: return boxBase(x);
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] spread(input logic [HALF_W-1:0] v);
    logic [7:0] y [8];
    for (int i = 0; i < 8; i++) y[i] = v[HALF_W-1-8*i -: 8];
    return {y[0]^y[2]^y[3]^y[5]^y[6]^y[7],
            y[0]^y[1]^y[3]^y[4]^y[6]^y[7],
            y[0]^y[1]^y[2]^y[4]^y[5]^y[7],
            y[1]^y[2]^y[3]^y[4]^y[5]^y[6],
            y[0]^y[1]^y[5]^y[6]^y[7],
            y[1]^y[2]^y[4]^y[6]^y[7],
            y[2]^y[3]^y[4]^y[5]^y[7],
            y[0]^y[3]^y[4]^y[5]^y[6]};
  endfunction

  function automatic logic [31:0] rol1(input logic [31:0] w);
    return {w[30:0], w[31]};
  endfunction

  function automatic logic [HALF_W-1:0] mixFwd(input logic [HALF_W-1:0] x, input logic [HALF_W-1:0] k);
    logic [31:0] hi, lo;
    lo = x[31:0] ^ rol1(x[63:32] & k[63:32]);
    hi = x[63:32] ^ (lo | k[31:0]);
    return {hi, lo};
  endfunction

  function automatic logic [HALF_W-1:0] mixInv(input logic [HALF_W-1:0] y, input logic [HALF_W-1:0] k);
    logic [31:0] hi, lo;
    hi = y[63:32] ^ (y[31:0] | k[31:0]);
    lo = y[31:0] ^ rol1(hi & k[63:32]);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/camFeistelRound.sv
module camFeistelRound
  import camFeistelPkg::*;
(
  input  logic [HALF_W-1:0] halfIn,
  input  logic [HALF_W-1:0] subKey,
  output logic [HALF_W-1:0] fOut
);
  logic [HALF_W-1:0] keyed, subst;

  assign keyed = halfIn ^ subKey;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    localparam int BOX = (l < 4) ? l : ((l == LANES - 1) ? 0 : l - 3);
    assign subst[HALF_W-1-8*l -: 8] = boxSel(BOX, keyed[HALF_W-1-8*l -: 8]);
  end

  assign fOut = spread(subst);
endmodule

// File: rtl/camFeistelCtl.sv
module camFeistelCtl
  import camFeistelPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             decrypt,
  output stepStb_t         stb,
  output logic [IDX_W-1:0] rndIdx,
  output logic [FL_W-1:0]  flSel,
  output logic             busy,
  output logic             done
);
  logic [STEP_W-1:0] stepQ;
  logic busyQ, decQ, doneQ, accept;
  int grp, pos, rnd;

  always_comb begin
    accept   = start && !busyQ;
    grp      = int'(stepQ) / (ROUNDS_PER_GROUP + 1);
    pos      = int'(stepQ) % (ROUNDS_PER_GROUP + 1);
    rnd      = grp * ROUNDS_PER_GROUP + pos;
    stb.load = accept;
    stb.rnd  = busyQ && (pos != ROUNDS_PER_GROUP);
    stb.fl   = busyQ && (pos == ROUNDS_PER_GROUP);
    stb.last = busyQ && (int'(stepQ) == STEP_COUNT - 1);
    stb.dec  = busyQ ? decQ : decrypt;
    rndIdx   = decQ ? IDX_W'(ROUND_COUNT - 1 - rnd) : IDX_W'(rnd);
    flSel    = decQ ? FL_W'(GROUP_COUNT - 2 - grp) : FL_W'(grp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      stepQ <= '0;
      decQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        busyQ <= 1'b1;
        stepQ <= '0;
        decQ  <= decrypt;
      end else if (busyQ) begin
        if (stb.last) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          stepQ <= stepQ + STEP_W'(1);
        end
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/camFeistelDp.sv
module camFeistelDp
  import camFeistelPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  stepStb_t           stb,
  input  logic [BLOCK_W-1:0] dataIn,
  input  logic [BLOCK_W-1:0] wKeyIn,
  input  logic [BLOCK_W-1:0] wKeyOut,
  input  logic [HALF_W-1:0]  rndKey,
  input  logic [HALF_W-1:0]  flKeyA,
  input  logic [HALF_W-1:0]  flKeyB,
  output logic [BLOCK_W-1:0] dataOut
);
  typedef enum logic [1:0] {SEL_LOAD = 2'd0, SEL_ROUND = 2'd1, SEL_FL = 2'd2, SEL_HOLD = 2'd3} stSel_e;

  logic [BLOCK_W-1:0] stateQ, resultQ, stateD, rndNext, flNext, preKey, postKey;
  logic [HALF_W-1:0]  leftW, rightW, fOut, flKeyL, flKeyR;
  stSel_e sel;

  assign leftW  = stateQ[BLOCK_W-1:HALF_W];
  assign rightW = stateQ[HALF_W-1:0];

  camFeistelRound uRound (.halfIn(leftW), .subKey(rndKey), .fOut(fOut));

  always_comb begin
    preKey  = stb.dec ? wKeyOut : wKeyIn;
    postKey = stb.dec ? wKeyIn  : wKeyOut;
    flKeyL  = stb.dec ? flKeyB  : flKeyA;
    flKeyR  = stb.dec ? flKeyA  : flKeyB;
    rndNext = stb.last ? {leftW, rightW ^ fOut} : {rightW ^ fOut, leftW};
    flNext  = {mixFwd(leftW, flKeyL), mixInv(rightW, flKeyR)};
    if (stb.load)     sel = SEL_LOAD;
    else if (stb.rnd) sel = SEL_ROUND;
    else if (stb.fl)  sel = SEL_FL;
    else              sel = SEL_HOLD;
    case (sel)
      SEL_LOAD:  stateD = dataIn ^ preKey;
      SEL_ROUND: stateD = rndNext;
      SEL_FL:    stateD = flNext;
      default:   stateD = stateQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= '0;
      resultQ <= '0;
    end else begin
      stateQ <= stateD;
      if (stb.last) resultQ <= rndNext ^ postKey;
    end
  end

  assign dataOut = resultQ;
endmodule

// File: rtl/camFeistelCore.sv
module camFeistelCore
  import camFeistelPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               decrypt,
  input  logic [BLOCK_W-1:0] dataIn,
  input  logic [BLOCK_W-1:0] wKeyIn,
  input  logic [BLOCK_W-1:0] wKeyOut,
  output logic [IDX_W-1:0]   rndKeyIdx,
  input  logic [HALF_W-1:0]  rndKey,
  output logic [FL_W-1:0]    flSel,
  input  logic [HALF_W-1:0]  flKeyA,
  input  logic [HALF_W-1:0]  flKeyB,
  output logic               done,
  output logic [BLOCK_W-1:0] dataOut
);
  stepStb_t stbW;
  logic busyW;

  camFeistelCtl uCtl (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt),
    .stb(stbW), .rndIdx(rndKeyIdx), .flSel(flSel), .busy(busyW), .done(done)
  );

  camFeistelDp uDp (
    .clk(clk), .rstN(rstN), .stb(stbW), .dataIn(dataIn),
    .wKeyIn(wKeyIn), .wKeyOut(wKeyOut), .rndKey(rndKey),
    .flKeyA(flKeyA), .flKeyB(flKeyB), .dataOut(dataOut)
  );
endmodule

// File: rtl/camFeistelChk.sv
module camFeistelChk
  import camFeistelPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input stepStb_t           stb,
  input logic [BLOCK_W-1:0] dataOut
);
  logic [STEP_W:0] latQ;
  logic runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latQ <= '0;
      runQ <= 1'b0;
    end else if (start && !busy) begin
      latQ <= '0;
      runQ <= 1'b1;
    end else begin
      if (runQ) latQ <= latQ + (STEP_W+1)'(1);
      if (done) runQ <= 1'b0;
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(latQ) == STEP_COUNT)); // R2
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.rnd, stb.fl})); // R8
  AST_LAST_IS_ROUND: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |-> (stb.rnd && busy)); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(dataOut)); // R10
endmodule

bind camFeistelCore camFeistelChk uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busyW),
  .done(done), .stb(stbW), .dataOut(dataOut)
);

// File: tb/tb_camFeistelCore.sv
`timescale 1ns/1ps
module tb_camFeistelCore;
  import camFeistelPkg::*;

  logic clk = 1'b0;
  logic rstN, start, decrypt, done;
  logic [BLOCK_W-1:0] dataIn, wKeyIn, wKeyOut, dataOut;
  logic [IDX_W-1:0] rndKeyIdx;
  logic [FL_W-1:0] flSel;
  logic [HALF_W-1:0] rndKey, flKeyA, flKeyB;

  logic [HALF_W-1:0] rk [ROUND_COUNT];
  logic [HALF_W-1:0] flk [2*(GROUP_COUNT-1)];

  always #2.5 clk = ~clk;

  assign rndKey = rk[rndKeyIdx];
  assign flKeyA = flk[{flSel, 1'b0}];
  assign flKeyB = flk[{flSel, 1'b1}];

  camFeistelCore dut (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt), .dataIn(dataIn),
    .wKeyIn(wKeyIn), .wKeyOut(wKeyOut), .rndKeyIdx(rndKeyIdx), .rndKey(rndKey),
    .flSel(flSel), .flKeyA(flKeyA), .flKeyB(flKeyB), .done(done), .dataOut(dataOut)
  );

  typedef struct packed {
    logic [BLOCK_W-1:0] pt;
    logic [63:0]        seed;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{128'h0123456789abcdeffedcba9876543210, 64'h0000_0000_0000_0001},
    '{128'h00000000000000000000000000000000, 64'h1357_9bdf_2468_ace0},
    '{128'hffffffffffffffffffffffffffffffff, 64'hdead_beef_cafe_f00d},
    '{128'h80000000000000000000000000000001, 64'h0f0f_1234_5678_9abc}
  };

  int checks = 0;
  int fails = 0;
  int n = 0;

  task automatic chk(input bit ok, input string req, input logic [BLOCK_W-1:0] act,
                     input logic [BLOCK_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] stepRand(input logic [63:0] s);
    return s * 64'd6364136223846793005 + 64'd1442695040888963407;
  endfunction

  task automatic setKeys(input logic [63:0] seed);
    logic [63:0] s;
    s = seed;
    for (int i = 0; i < ROUND_COUNT; i++) begin s = stepRand(s); rk[i] = s; end
    for (int i = 0; i < 2*(GROUP_COUNT-1); i++) begin s = stepRand(s); flk[i] = s; end
    s = stepRand(s); wKeyIn[127:64] = s;
    s = stepRand(s); wKeyIn[63:0] = s;
    s = stepRand(s); wKeyOut[127:64] = s;
    s = stepRand(s); wKeyOut[63:0] = s;
  endtask

  task automatic kick(input bit dec, input logic [BLOCK_W-1:0] din);
    @(negedge clk);
    start = 1'b1; decrypt = dec; dataIn = din;
    @(negedge clk);
    start = 1'b0;
    n = 1;
  endtask

  task automatic finish(input bit dec, output logic [BLOCK_W-1:0] dout, output int lat,
                        output bit ordOk);
    int s, g, p, r, e;
    ordOk = 1'b1;
    while (!done && n < 100) begin
      if (n <= STEP_COUNT) begin
        s = n - 1;
        g = s / (ROUNDS_PER_GROUP + 1);
        p = s % (ROUNDS_PER_GROUP + 1);
        if (p == ROUNDS_PER_GROUP) begin
          e = dec ? GROUP_COUNT - 2 - g : g;
          if (int'(flSel) != e) ordOk = 1'b0;
        end else begin
          r = g * ROUNDS_PER_GROUP + p;
          e = dec ? ROUND_COUNT - 1 - r : r;
          if (int'(rndKeyIdx) != e) ordOk = 1'b0;
        end
      end
      @(negedge clk);
      n++;
    end
    lat = n - 1;
    dout = dataOut;
  endtask

  task automatic runOp(input bit dec, input logic [BLOCK_W-1:0] din,
                       output logic [BLOCK_W-1:0] dout, output int lat, output bit ordOk);
    kick(dec, din);
    finish(dec, dout, lat, ordOk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [BLOCK_W-1:0] ct, back, c0, res, d, held;
    logic [BLOCK_W-1:0] p0;
    int lat;
    bit ok, sawDone;

    rstN = 1'b0; start = 1'b0; decrypt = 1'b0; dataIn = '0;
    setKeys(64'h42);
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && dataOut == '0, "R1 reset state", dataOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && dataOut == '0, "R1 after release", dataOut, '0);

    for (int v = 0; v < NVEC; v++) begin
      setKeys(VECS[v].seed);
      runOp(1'b0, VECS[v].pt, ct, lat, ok);
      chk(lat == STEP_COUNT, "R2 encrypt latency", 128'(lat), 128'(STEP_COUNT));
      chk(ok, "R8 encrypt key order", 128'(ok), 128'(1));
      chk(ct != VECS[v].pt, "R7 ciphertext differs", ct, ~VECS[v].pt);
      runOp(1'b1, ct, back, lat, ok);
      chk(lat == STEP_COUNT, "R2 decrypt latency", 128'(lat), 128'(STEP_COUNT));
      chk(ok, "R8 decrypt key order", 128'(ok), 128'(1));
      chk(back == VECS[v].pt, "R7 round trip", back, VECS[v].pt);
      @(negedge clk);
      chk(done == 1'b0, "R3 single-cycle done", 128'(done), '0);
    end

    p0 = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    d  = 128'h00ff00ff_12345678_a5a5a5a5_deadbeef;
    setKeys(64'h77);
    runOp(1'b0, p0, c0, lat, ok);

    wKeyIn = wKeyIn ^ d;
    runOp(1'b0, p0 ^ d, res, lat, ok);
    chk(res == c0, "R5 encrypt pre-whitening", res, c0);
    wKeyIn = wKeyIn ^ d;

    wKeyOut = wKeyOut ^ d;
    runOp(1'b0, p0, res, lat, ok);
    chk(res == (c0 ^ d), "R6 encrypt post-whitening", res, c0 ^ d);
    wKeyOut = wKeyOut ^ d;

    wKeyIn = wKeyIn ^ d;
    runOp(1'b1, c0, res, lat, ok);
    chk(res == (p0 ^ d), "R9 decrypt output whitening", res, p0 ^ d);
    wKeyIn = wKeyIn ^ d;

    wKeyOut = wKeyOut ^ d;
    runOp(1'b1, c0 ^ d, res, lat, ok);
    chk(res == p0, "R9 decrypt input whitening", res, p0);
    wKeyOut = wKeyOut ^ d;

    kick(1'b0, p0);
    repeat (4) begin @(negedge clk); n++; end
    start = 1'b1; decrypt = 1'b1; dataIn = ~p0;
    repeat (3) begin @(negedge clk); n++; end
    start = 1'b0;
    finish(1'b0, res, lat, ok);
    chk(res == c0, "R4 start ignored while busy", res, c0);
    chk(lat == STEP_COUNT, "R4 latency from first start", 128'(lat), 128'(STEP_COUNT));
    sawDone = 1'b0;
    repeat (25) begin @(negedge clk); if (done) sawDone = 1'b1; end
    chk(!sawDone, "R4 no extra completion", 128'(sawDone), '0);

    held = dataOut;
    dataIn = ~dataIn;
    wKeyOut = wKeyOut ^ d;
    wKeyIn = wKeyIn ^ d;
    repeat (10) @(negedge clk);
    chk(dataOut == held, "R10 result held", dataOut, held);
    wKeyOut = wKeyOut ^ d;
    wKeyIn = wKeyIn ^ d;

    kick(1'b0, p0);
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && dataOut == '0, "R1 reset mid-operation", dataOut, '0);
    rstN = 1'b1;
    sawDone = 1'b0;
    repeat (25) begin @(negedge clk); if (done) sawDone = 1'b1; end
    chk(!sawDone, "R1 abandoned operation", 128'(sawDone), '0);
    runOp(1'b0, p0, res, lat, ok);
    chk(res == c0, "R1 clean run after reset", res, c0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule